// File: doc/BRIEF.md
# RC Oscillator Trim Calibrator

This block holds the 8-bit trim code that tunes an on-chip RC oscillator and contains a hardware engine that finds a good code on its own. The code has an inverse sense: a smaller code gives a faster oscillator, and a larger code gives a slower one. The calibration engine runs a bitwise successive-approximation search that begins at the mid-scale code. It tests one bit per measurement window, from the most significant bit down to the least significant bit. Each window is run by an external frequency counter, which compares the oscillator against a reference and reports back only whether the clock is too fast.

Each step presents the trial code and raises a one-cycle request for a measurement window. The engine then waits, for any number of cycles, until the counter returns a result pulse. On that result the engine keeps or clears the trial bit and moves to the next lower bit. After the last bit it raises `done_o` and holds the code. Software can also load a stored code directly through a write port. A write during a search stops the search at once.

Top module: `rc_trim_cal`

## Requirements
- R1: During reset and in the first cycle after reset, `trim_o` is FFh, and `busy_o`, `done_o` and `meas_start_o` are all low.
- R2: Code 00h is the fastest setting and FFh is the slowest. When the result pulse carries `meas_fast_i`=1 ("too fast"), the engine keeps the trial bit at 1, which moves the code toward slower. When `meas_fast_i`=0, the engine clears the trial bit to 0.
- R3: A start pulse that arrives while the engine is idle, with no write in the same cycle, is accepted. In the next cycle `trim_o` is 80h, `busy_o` is 1, and `meas_start_o` is high for exactly that one cycle.
- R4: A result pulse during a waiting window is applied at the next clock edge. From that cycle, `trim_o` shows the decided trial bit with the next lower bit set to 1. In the same cycle `meas_start_o` pulses for one cycle. `trim_o` does not change while the engine waits for a result.
- R5: A search uses exactly 8 measurement windows. In the cycle after the 8th result, `done_o`=1 and `busy_o`=0. The final code is then held until the next accepted start or the next write. `done_o` and `busy_o` are never high together.
- R6: A result pulse outside a waiting window is ignored. This holds in the idle state and in the cycle in which `meas_start_o` is high.
- R7: A start pulse while `busy_o`=1 is ignored. The search continues and `trim_o` is unchanged.
- R8: A write (`wr_en_i`=1) sets `trim_o` to `wr_data_i` in the next cycle and clears `busy_o` and `done_o`. A write aborts any search in progress. A write takes priority over a start pulse in the same cycle.
- R9: Suppose the counter reports "too fast" exactly when the trim code is below a threshold T, with 0 ≤ T ≤ 256. Then a search ends with code T−1 when T ≥ 1, and with code 00h when T = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle request to begin a calibration search |
| wr_en_i | input | 1 | Direct write strobe for the trim code |
| wr_data_i | input | 8 | Trim code to load on a write |
| meas_done_i | input | 1 | Single-cycle result pulse from the frequency counter |
| meas_fast_i | input | 1 | Result value: 1 means too fast, 0 means not too fast; valid with `meas_done_i` |
| trim_o | output | 8 | Current trim code driven to the oscillator |
| busy_o | output | 1 | A search is in progress |
| done_o | output | 1 | The last search finished; the code is the search result |
| meas_start_o | output | 1 | Single-cycle request to open a measurement window |

## Verification
A wrong bit mask or a wrong decision shows on `trim_o` in the cycle after the result pulse that caused it. A wrong starting state shows one cycle after an accepted start, because the code must then be exactly 80h. A wrong step count appears at the end of the search: either `done_o` rises after the wrong number of window requests, or the final code differs from T−1 for the threshold used. Dropped aborts and dropped ignore rules show on `trim_o` or `busy_o` one cycle after the write, start or stray result pulse.

// File: rtl/rct_pkg.sv
package rct_pkg;

    // Sequencer phases of a calibration search
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // no search; code holds
        ST_TRIAL = 2'd1,   // trial code just applied, window requested
        ST_WAIT  = 2'd2    // waiting for the counter's result pulse
    } seq_state_e;

    // Acceptance strobes that the sequencer hands to the datapath
    typedef struct packed {
        logic start_acc;   // start taken: load mid-scale code
        logic step_acc;    // result taken: load decided code
    } seq_strobe_t;

endpackage

// File: rtl/rct_trim_reg.sv
module rct_trim_reg #(
    parameter int TRIM_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [TRIM_W-1:0] wr_data_i,
    input  logic              ld_en_i,
    input  logic [TRIM_W-1:0] ld_data_i,
    output logic [TRIM_W-1:0] trim_o
);
    localparam logic [TRIM_W-1:0] SLOWEST = '1;

    logic [TRIM_W-1:0] trim_q;

    // A write from the bus wins over a load from the engine
    always_ff @(posedge clk) begin
        if (rst)          trim_q <= SLOWEST;
        else if (wr_en_i) trim_q <= wr_data_i;
        else if (ld_en_i) trim_q <= ld_data_i;
    end

    assign trim_o = trim_q;
endmodule

// File: rtl/rct_sar_step.sv
module rct_sar_step #(
    parameter int TRIM_W = 8
) (
    input  logic [TRIM_W-1:0] code_i,
    input  logic [TRIM_W-1:0] mask_i,   // one-hot: bit under test
    input  logic              fast_i,   // 1: too fast, keep the bit (slower)
    output logic [TRIM_W-1:0] next_code_o
);
    for (genvar i = 0; i < TRIM_W; i++) begin : g_bit
        logic kept;
        assign kept = mask_i[i] ? (code_i[i] & fast_i) : code_i[i];
        if (i == TRIM_W - 1) begin : g_top
            assign next_code_o[i] = kept;
        end else begin : g_low
            // the bit under the one just decided becomes the next trial
            assign next_code_o[i] = kept | mask_i[i+1];
        end
    end
endmodule

// File: rtl/rct_seq.sv
module rct_seq
    import rct_pkg::*;
#(
    parameter int TRIM_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              wr_en_i,
    input  logic              meas_done_i,
    output seq_strobe_t       strobe_o,
    output logic [TRIM_W-1:0] mask_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              meas_start_o
);
    localparam logic [TRIM_W-1:0] TOP_MASK = {1'b1, {(TRIM_W-1){1'b0}}};

    seq_state_e        state_q;
    logic [TRIM_W-1:0] mask_q;
    logic              done_q;

    assign strobe_o.start_acc = start_i && (state_q == ST_IDLE) && !wr_en_i;
    assign strobe_o.step_acc  = meas_done_i && (state_q == ST_WAIT) && !wr_en_i;

    always_ff @(posedge clk) begin
        if (rst || wr_en_i) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_TRIAL;
                        mask_q  <= TOP_MASK;
                        done_q  <= 1'b0;
                    end
                end
                ST_TRIAL: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (meas_done_i) begin
                        if (mask_q[0]) begin
                            state_q <= ST_IDLE;
                            mask_q  <= '0;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= ST_TRIAL;
                            mask_q  <= mask_q >> 1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mask_o       = mask_q;
    assign busy_o       = (state_q != ST_IDLE);
    assign done_o       = done_q;
    assign meas_start_o = (state_q == ST_TRIAL);
endmodule

// File: rtl/rc_trim_cal.sv
module rc_trim_cal
    import rct_pkg::*;
#(
    parameter int TRIM_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              wr_en_i,
    input  logic [TRIM_W-1:0] wr_data_i,
    input  logic              meas_done_i,
    input  logic              meas_fast_i,
    output logic [TRIM_W-1:0] trim_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              meas_start_o
);
    localparam logic [TRIM_W-1:0] MID_CODE = {1'b1, {(TRIM_W-1){1'b0}}};

    seq_strobe_t       strobe;
    logic [TRIM_W-1:0] mask;
    logic [TRIM_W-1:0] next_code;
    logic [TRIM_W-1:0] ld_data;
    logic              ld_en;

    rct_seq #(.TRIM_W(TRIM_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .wr_en_i      (wr_en_i),
        .meas_done_i  (meas_done_i),
        .strobe_o     (strobe),
        .mask_o       (mask),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .meas_start_o (meas_start_o)
    );

    rct_sar_step #(.TRIM_W(TRIM_W)) u_step (
        .code_i      (trim_o),
        .mask_i      (mask),
        .fast_i      (meas_fast_i),
        .next_code_o (next_code)
    );

    assign ld_en   = strobe.start_acc | strobe.step_acc;
    assign ld_data = strobe.start_acc ? MID_CODE : next_code;

    rct_trim_reg #(.TRIM_W(TRIM_W)) u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .ld_en_i   (ld_en),
        .ld_data_i (ld_data),
        .trim_o    (trim_o)
    );
endmodule

// File: rtl/rc_trim_cal_chk.sv
module rc_trim_cal_chk #(
    parameter int TRIM_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              wr_en_i,
    input logic [TRIM_W-1:0] wr_data_i,
    input logic              meas_done_i,
    input logic [TRIM_W-1:0] trim_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              meas_start_o
);
    localparam int CW = $clog2(TRIM_W + 1) + 1;
    localparam logic [TRIM_W-1:0] MID_CODE = {1'b1, {(TRIM_W-1){1'b0}}};

    // windows requested since the last accepted start
    logic [CW-1:0] win_cnt;
    always_ff @(posedge clk) begin
        if (rst || wr_en_i)                     win_cnt <= '0;
        else if (start_i && !busy_o)            win_cnt <= '0;
        else if (meas_start_o)                  win_cnt <= win_cnt + 1'b1;
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (trim_o == '1 && !busy_o && !done_o && !meas_start_o)); // R1

    AST_START_MID: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && !wr_en_i) |=> (trim_o == MID_CODE && busy_o && meas_start_o)); // R3

    AST_REQ_IN_SEARCH: assert property (@(posedge clk) disable iff (rst)
        meas_start_o |-> busy_o); // R4

    AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !meas_done_i && !wr_en_i) |=> $stable(trim_o)); // R4

    AST_DONE_BUSY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done_o && busy_o)); // R5

    AST_EIGHT_WINDOWS: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> (win_cnt == CW'(TRIM_W) && $past(busy_o))); // R5

    AST_BUSY_START_IGN: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !wr_en_i && !meas_done_i) |=> (busy_o && $stable(trim_o))); // R7

    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (trim_o == $past(wr_data_i) && !busy_o && !done_o)); // R8
endmodule

bind rc_trim_cal rc_trim_cal_chk #(.TRIM_W(TRIM_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .meas_done_i  (meas_done_i),
    .trim_o       (trim_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .meas_start_o (meas_start_o)
);

// File: tb/rc_trim_cal_test.sv
module rc_trim_cal_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       meas_done_i;
    logic       meas_fast_i;
    logic [7:0] trim_o;
    logic       busy_o, done_o, meas_start_o;

    // counter model: automatic responder plus manual pulses from tasks
    logic resp_done = 1'b0, resp_fast = 1'b0;
    logic man_done = 1'b0, man_fast = 1'b0;
    bit   resp_en = 1'b0;
    int   resp_delay = 1;
    int   thr = 0;
    int   win_seen = 0;
    int   errors = 0, checks = 0;
    bit   finished = 1'b0;

    assign meas_done_i = resp_done | man_done;
    assign meas_fast_i = man_done ? man_fast : resp_fast;

    always #10 clk = ~clk;   // 50 MHz

    rc_trim_cal uut (
        .clk(clk), .rst(rst), .start_i(start_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .meas_done_i(meas_done_i), .meas_fast_i(meas_fast_i),
        .trim_o(trim_o), .busy_o(busy_o), .done_o(done_o), .meas_start_o(meas_start_o)
    );

    // responder: answers each window request after resp_delay cycles
    initial begin
        int cnt = -1;
        forever begin
            @(negedge clk);
            resp_done = 1'b0;
            if (meas_start_o) win_seen++;
            if (resp_en && meas_start_o) cnt = resp_delay;
            else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    resp_done = 1'b1;
                    resp_fast = (int'(trim_o) < thr);
                    cnt = -1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int expected_code(input int t);
        if (t == 0) return 0;
        if (t > 255) return 255;
        return t - 1;
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(trim_o == 8'hFF, "R1", "trim in reset", trim_o, 8'hFF);
        rst = 1'b0;
        @(negedge clk);
        chk(trim_o == 8'hFF, "R1", "trim after reset", trim_o, 8'hFF);
        chk(!busy_o && !done_o && !meas_start_o, "R1", "flags after reset",
            {busy_o, done_o, meas_start_o}, 0);
    endtask

    task automatic t_search(input int t, input int dly);
        int guard = 0;
        thr = t; resp_delay = dly; resp_en = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        win_seen = 0;
        if (meas_start_o) win_seen = 1;   // first request seen here
        chk(trim_o == 8'h80 && busy_o && meas_start_o, "R3", "start state",
            {trim_o, busy_o, meas_start_o}, {8'h80, 2'b11});
        while (!done_o && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        chk(done_o && !busy_o, "R5", "done after search", {done_o, busy_o}, 2'b10);
        chk(win_seen == 8, "R5", "window count", win_seen, 8);
        chk(int'(trim_o) == expected_code(t), "R9", $sformatf("result thr=%0d", t),
            trim_o, expected_code(t));
        repeat (3) @(negedge clk);
        chk(int'(trim_o) == expected_code(t) && done_o, "R5", "result held",
            trim_o, expected_code(t));
        resp_en = 1'b0;
    endtask

    // manual stepping: decision polarity, ignore rules, write abort
    task automatic t_manual();
        resp_en = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;                       // TRIAL, code 80
        @(negedge clk);                       // WAIT
        chk(trim_o == 8'h80 && !meas_start_o, "R4", "hold while waiting", trim_o, 8'h80);
        man_done = 1'b1; man_fast = 1'b1;     // too fast: keep bit 7
        @(negedge clk);
        man_done = 1'b0;
        chk(trim_o == 8'hC0 && meas_start_o, "R2", "fast keeps bit", trim_o, 8'hC0);
        @(negedge clk);                       // WAIT
        man_done = 1'b1; man_fast = 1'b0;     // not fast: clear bit 6
        @(negedge clk);
        man_done = 1'b0;
        chk(trim_o == 8'hA0 && meas_start_o, "R2", "slow clears bit", trim_o, 8'hA0);
        man_done = 1'b1; man_fast = 1'b1;     // during TRIAL: ignored
        @(negedge clk);
        man_done = 1'b0;
        chk(trim_o == 8'hA0 && busy_o, "R6", "result in trial cycle ignored", trim_o, 8'hA0);
        start_i = 1'b1;                       // start while busy
        @(negedge clk);
        start_i = 1'b0;
        chk(trim_o == 8'hA0 && busy_o && !meas_start_o, "R7", "start while busy ignored",
            trim_o, 8'hA0);
        wr_en_i = 1'b1; wr_data_i = 8'h5A;    // abort by write
        @(negedge clk);
        wr_en_i = 1'b0;
        chk(trim_o == 8'h5A && !busy_o && !done_o, "R8", "write aborts search",
            trim_o, 8'h5A);
        man_done = 1'b1; man_fast = 1'b0;     // idle: ignored
        @(negedge clk);
        man_done = 1'b0;
        @(negedge clk);
        chk(trim_o == 8'h5A && !busy_o && !meas_start_o, "R6", "result while idle ignored",
            trim_o, 8'h5A);
    endtask

    task automatic t_write_priority();
        wr_en_i = 1'b1; wr_data_i = 8'h3C; start_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; start_i = 1'b0;
        chk(trim_o == 8'h3C && !busy_o, "R8", "write beats start", trim_o, 8'h3C);
        @(negedge clk);
        chk(trim_o == 8'h3C && !meas_start_o, "R8", "no search after write", trim_o, 8'h3C);
    endtask

    task automatic t_write_after_done();
        t_search(8'h47, 2);
        wr_en_i = 1'b1; wr_data_i = 8'hE1;
        @(negedge clk);
        wr_en_i = 1'b0;
        chk(trim_o == 8'hE1 && !done_o, "R8", "write clears done", trim_o, 8'hE1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_manual();
        t_write_priority();
        t_search(0, 1);
        t_search(256, 1);
        t_search(1, 3);
        t_search(8'h80, 2);
        t_search(8'h81, 1);
        t_search(8'h37, 5);
        t_search(8'hC5, 1);
        t_search(255, 4);
        t_write_after_done();
        t_search(8'h12, 1);                   // restart after a write
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule